// File: doc/BRIEF.md
# Atomic Filter Coefficient Upload Controller

This block sits between a byte-wide host register port and the coefficient store of an audio filter. Each coefficient is a signed 24-bit fixed-point number covering -1 up to just below +1; a negative value inverts phase. The host stages coefficients in fifteen byte registers, three bytes per coefficient with the most significant byte first. Five staged coefficients make one biquad set, in the order b1, b2, a1, a2, b0. The host then picks a start address and starts a transfer through a command register.

A single write or single read moves one coefficient between staging word 0 and the RAM. A set read fills all five staging words from five consecutive RAM entries. A set write first copies the fifteen staged bytes into a shadow buffer. On the next sample-boundary strobe, the shadow is swapped into all five RAM entries in one clock edge, so the filter never sees a half-written biquad.

The RAM holds 62 entries. Addresses 0 to 49 hold ten biquad sets, one every fifth address. Addresses 50 to 61 hold prescale, postscale and mix values. Every register read returns live state, and the filter reads the RAM through its own combinational port.

Top module: `coef_upload_ctrl`

## Requirements
- R1: After reset, every staging byte, the address register, the command register and every RAM entry read 0, and `busy` is low.
- R2: Host offsets 0..14 are staging bytes, and offset 3k holds the most significant byte of staging word k. Offset 15 is the 6-bit coefficient address, read back zero-extended. Offset 16 is the command register. Any other offset reads 0.
- R3: Command bit 0 (single write) writes staging word 0 into RAM at the coefficient address on the edge after the command write. `busy` is high for exactly that one cycle.
- R4: Command bit 2 (single read) loads staging bytes 0..2 from RAM at the coefficient address and leaves bytes 3..14 unchanged. `busy` is high for one cycle.
- R5: Command bit 3 (set read) loads staging word k from RAM at address+k for k = 0..4, in the order b1, b2, a1, a2, b0. `busy` is high for one cycle.
- R6: Command bit 1 (set write) captures the five staging words in the cycle after the command write. RAM is then left unchanged until the first `sampleStrobe` sampled at an edge after that capture cycle. On that edge all five entries address..address+4 change together and `busy` falls.
- R7: While `busy` is high, host writes to the staging bytes and to the address register have no effect.
- R8: A set command at an address above 57, or a single command at an address above 61, changes neither RAM nor staging, and `busy` falls after one cycle.
- R9: If a command write sets several of bits 0..3, only the lowest-numbered set bit runs.
- R10: Bits 7..4 of the command register keep the value of the last host write to it, including writes made while busy. Bits 3..0 read back the pending command and return to 0 when it finishes. A command written while busy is discarded.
- R11: `filtData` shows the RAM entry at `filtAddr` combinationally, and shows 0 for addresses 62 and 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 5 | Host register offset |
| hostWe | input | 1 | Host write enable |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Live read byte at hostAddr |
| busy | output | 1 | Transfer pending or in progress |
| sampleStrobe | input | 1 | Sample boundary pulse that releases a set write |
| filtAddr | input | 6 | Filter-side RAM read address |
| filtData | output | 24 | Filter-side RAM read data |

## Verification
Every RAM address is filled through single writes with arithmetically generated values that include negative numbers, and then read back through the filter port. This exposes address decoding faults and byte-order swaps. Set reads at every biquad base, plus the last legal base 57, distinguish the b1..b0 ordering from a shifted or reversed one. Set writes are held across several idle cycles and across a strobe that arrives in the capture cycle, which separates an atomic swap from an early or partial one. Out-of-range bases, multi-bit commands and writes made while busy show that rejection, priority and locking each leave the ports unchanged.

// File: rtl/coef_pkg.sv
`timescale 1ns/1ps
package coef_pkg;
  localparam int CMD_WR_ONE = 0;
  localparam int CMD_WR_SET = 1;
  localparam int CMD_RD_ONE = 2;
  localparam int CMD_RD_SET = 3;
  localparam int CMD_BITS   = 4;

  typedef struct packed {
    logic wrOne;   // write staging word 0 into RAM
    logic wrLoad;  // capture staging words into shadow
    logic wrSwap;  // commit shadow set into RAM
    logic rdOne;   // load staging word 0 from RAM
    logic rdSet;   // load all staging words from RAM
  } xferStrobe_t;
endpackage

// File: rtl/coef_xfer_ctrl.sv
`timescale 1ns/1ps
module coef_xfer_ctrl
  import coef_pkg::*;
#(
  parameter int DEPTH   = 62,
  parameter int SET_LEN = 5,
  parameter int ADDR_W  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic [7:0]          ctrlWdata,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic                sampleStrobe,
  output xferStrobe_t         strobes,
  output logic [CMD_BITS-1:0] cmdBits,
  output logic [7-CMD_BITS:0] reservedBits,
  output logic                waitSwap,
  output logic                busy
);
  localparam int LAST_SET_BASE = DEPTH - SET_LEN;

  logic [CMD_BITS-1:0] pickBits;
  logic validOne, validSet, execNow;

  // lowest set command bit wins
  always_comb begin
    pickBits = '0;
    for (int i = CMD_BITS - 1; i >= 0; i--) begin
      if (ctrlWdata[i]) begin
        pickBits    = '0;
        pickBits[i] = 1'b1;
      end
    end
  end

  assign busy     = |cmdBits;
  assign validOne = int'(curAddr) < DEPTH;
  assign validSet = int'(curAddr) <= LAST_SET_BASE;
  assign execNow  = busy && !waitSwap;

  always_comb begin
    strobes        = '0;
    strobes.wrOne  = execNow && cmdBits[CMD_WR_ONE] && validOne;
    strobes.rdOne  = execNow && cmdBits[CMD_RD_ONE] && validOne;
    strobes.rdSet  = execNow && cmdBits[CMD_RD_SET] && validSet;
    strobes.wrLoad = execNow && cmdBits[CMD_WR_SET] && validSet;
    strobes.wrSwap = waitSwap && sampleStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBits      <= '0;
      reservedBits <= '0;
      waitSwap     <= 1'b0;
    end else begin
      if (ctrlWr) reservedBits <= ctrlWdata[7:CMD_BITS];
      if (!busy) begin
        if (ctrlWr) cmdBits <= pickBits;
      end else if (waitSwap) begin
        if (sampleStrobe) begin
          cmdBits  <= '0;
          waitSwap <= 1'b0;
        end
      end else if (strobes.wrLoad) begin
        waitSwap <= 1'b1;
      end else begin
        cmdBits <= '0;
      end
    end
  end
endmodule

// File: rtl/coef_xfer_dpath.sv
`timescale 1ns/1ps
module coef_xfer_dpath
  import coef_pkg::*;
#(
  parameter int COEF_W  = 24,
  parameter int DEPTH   = 62,
  parameter int SET_LEN = 5,
  parameter int ADDR_W  = 6,
  parameter int HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWe,
  input  logic [7:0]         hostWdata,
  input  logic               busy,
  input  xferStrobe_t        strobes,
  input  logic [ADDR_W-1:0]  filtAddr,
  output logic [7:0]         regRdata,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [COEF_W-1:0]  filtData
);
  localparam int BPC         = COEF_W / 8;
  localparam int STAGE_BYTES = SET_LEN * BPC;
  localparam int ADDR_OFF    = STAGE_BYTES;

  logic [7:0]        stage    [STAGE_BYTES];
  logic [COEF_W-1:0] stageWord[SET_LEN];
  logic [COEF_W-1:0] shadow   [SET_LEN];
  logic [COEF_W-1:0] setWord  [SET_LEN];
  logic [COEF_W-1:0] ram      [DEPTH];
  logic              wrHit    [DEPTH];
  logic [COEF_W-1:0] wrVal    [DEPTH];

  // big-endian packing of staging bytes into words
  always_comb begin
    for (int k = 0; k < SET_LEN; k++)
      for (int b = 0; b < BPC; b++)
        stageWord[k][COEF_W-1-8*b -: 8] = stage[k*BPC+b];
  end

  // RAM words at curAddr+k, zero past the end
  always_comb begin
    for (int k = 0; k < SET_LEN; k++) begin
      setWord[k] = '0;
      for (int i = 0; i < DEPTH; i++)
        if (i == int'(curAddr) + k) setWord[k] = ram[i];
    end
  end

  always_comb begin
    filtData = '0;
    for (int i = 0; i < DEPTH; i++)
      if (i == int'(filtAddr)) filtData = ram[i];
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < STAGE_BYTES; i++)
      if (int'(hostAddr) == i) regRdata = stage[i];
    if (int'(hostAddr) == ADDR_OFF) regRdata = {{(8-ADDR_W){1'b0}}, curAddr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGE_BYTES; i++) stage[i] <= '0;
      curAddr <= '0;
    end else if (strobes.rdSet) begin
      for (int k = 0; k < SET_LEN; k++)
        for (int b = 0; b < BPC; b++)
          stage[k*BPC+b] <= setWord[k][COEF_W-1-8*b -: 8];
    end else if (strobes.rdOne) begin
      for (int b = 0; b < BPC; b++)
        stage[b] <= setWord[0][COEF_W-1-8*b -: 8];
    end else if (hostWe && !busy) begin
      for (int i = 0; i < STAGE_BYTES; i++)
        if (int'(hostAddr) == i) stage[i] <= hostWdata;
      if (int'(hostAddr) == ADDR_OFF) curAddr <= hostWdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < SET_LEN; k++) shadow[k] <= '0;
    end else if (strobes.wrLoad) begin
      for (int k = 0; k < SET_LEN; k++) shadow[k] <= stageWord[k];
    end
  end

  // per-entry write select: swap of a whole set, or one word
  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : gEntry
      always_comb begin
        wrHit[gi] = strobes.wrOne && (int'(curAddr) == gi);
        wrVal[gi] = stageWord[0];
        for (int k = 0; k < SET_LEN; k++) begin
          if (strobes.wrSwap && (int'(curAddr) + k == gi)) begin
            wrHit[gi] = 1'b1;
            wrVal[gi] = shadow[k];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wrHit[i]) ram[i] <= wrVal[i];
    end
  end
endmodule

// File: rtl/coef_upload_ctrl.sv
`timescale 1ns/1ps
module coef_upload_ctrl
  import coef_pkg::*;
#(
  parameter int COEF_W  = 24,
  parameter int DEPTH   = 62,
  parameter int SET_LEN = 5,
  localparam int ADDR_W      = $clog2(DEPTH),
  localparam int STAGE_BYTES = SET_LEN * (COEF_W / 8),
  localparam int HOST_AW     = $clog2(STAGE_BYTES + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWe,
  input  logic [7:0]         hostWdata,
  output logic [7:0]         hostRdata,
  output logic               busy,
  input  logic               sampleStrobe,
  input  logic [ADDR_W-1:0]  filtAddr,
  output logic [COEF_W-1:0]  filtData
);
  localparam int ADDR_OFF = STAGE_BYTES;
  localparam int CTRL_OFF = STAGE_BYTES + 1;

  xferStrobe_t         strobes;
  logic [CMD_BITS-1:0] cmdBits;
  logic [7-CMD_BITS:0] reservedBits;
  logic                waitSwap;
  logic [ADDR_W-1:0]   curAddr;
  logic [7:0]          regRdata;
  logic                ctrlWr;

  assign ctrlWr    = hostWe && (int'(hostAddr) == CTRL_OFF);
  assign hostRdata = (int'(hostAddr) == CTRL_OFF) ? {reservedBits, cmdBits} : regRdata;

  coef_xfer_ctrl #(.DEPTH(DEPTH), .SET_LEN(SET_LEN), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(hostWdata),
    .curAddr(curAddr), .sampleStrobe(sampleStrobe), .strobes(strobes),
    .cmdBits(cmdBits), .reservedBits(reservedBits), .waitSwap(waitSwap), .busy(busy)
  );

  coef_xfer_dpath #(.COEF_W(COEF_W), .DEPTH(DEPTH), .SET_LEN(SET_LEN),
                    .ADDR_W(ADDR_W), .HOST_AW(HOST_AW)) uDpath (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .busy(busy), .strobes(strobes), .filtAddr(filtAddr),
    .regRdata(regRdata), .curAddr(curAddr), .filtData(filtData)
  );
endmodule

// File: rtl/coef_upload_chk.sv
`timescale 1ns/1ps
module coef_upload_chk #(
  parameter int HOST_AW   = 5,
  parameter int ADDR_W    = 6,
  parameter int COEF_W    = 24,
  parameter int CTRL_OFF  = 16,
  parameter int ADDR_OFF  = 15,
  parameter int LAST_BASE = 57
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic [3:0]         cmdBits,
  input logic [3:0]         reservedBits,
  input logic               waitSwap,
  input logic               sampleStrobe,
  input logic               hostWe,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [ADDR_W-1:0]  curAddr,
  input logic [ADDR_W-1:0]  filtAddr,
  input logic [COEF_W-1:0]  filtData
);
  assert_cmd_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdBits));

  assert_addr_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy && hostWe && int'(hostAddr) == ADDR_OFF |=> $stable(curAddr));

  assert_set_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    waitSwap && !sampleStrobe |=> (!$stable(filtAddr) || $stable(filtData)));

  assert_swap_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    waitSwap && sampleStrobe |=> !busy);

  // single write/read and set read all finish in one cycle (R3, R4, R5)
  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy && !waitSwap && !cmdBits[1] |=> !busy);

  assert_bad_base_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !waitSwap && cmdBits[1] && int'(curAddr) > LAST_BASE |=> !busy);

  assert_reserved_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWe && int'(hostAddr) == CTRL_OFF) |=> $stable(reservedBits));
endmodule

bind coef_upload_ctrl coef_upload_chk #(
  .HOST_AW(HOST_AW), .ADDR_W(ADDR_W), .COEF_W(COEF_W),
  .CTRL_OFF(CTRL_OFF), .ADDR_OFF(ADDR_OFF), .LAST_BASE(DEPTH - SET_LEN)
) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .cmdBits(cmdBits),
  .reservedBits(reservedBits), .waitSwap(waitSwap), .sampleStrobe(sampleStrobe),
  .hostWe(hostWe), .hostAddr(hostAddr), .curAddr(curAddr),
  .filtAddr(filtAddr), .filtData(filtData)
);

// File: tb/sim_coef_upload_ctrl.sv
`timescale 1ns/1ps
module sim_coef_upload_ctrl;
  localparam int DEPTH = 62, NSTG = 15, ADDR_OFF = 15, CTRL_OFF = 16;

  logic clk = 1'b0, rstN = 1'b0, hostWe = 1'b0, sampleStrobe = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [5:0]  filtAddr = '0;
  logic [7:0]  hostRdata;
  logic        busy;
  logic [23:0] filtData;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [23:0] mram [DEPTH];
  logic [7:0]  mstg [NSTG];

  coef_upload_ctrl u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busy(busy),
    .sampleStrobe(sampleStrobe), .filtAddr(filtAddr), .filtData(filtData)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] coefVal(input int a, input int salt);
    return 24'(a * 32'h3A5F17 + salt * 32'h1234D + 32'h800123);
  endfunction

  function automatic logic [23:0] mword(input int k);
    return {mstg[3*k], mstg[3*k+1], mstg[3*k+2]};
  endfunction

  task automatic hw(input int a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = 5'(a); hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic rdReg(input int a, output logic [7:0] d);
    hostAddr = 5'(a); #0.2; d = hostRdata;
  endtask

  task automatic putWord(input int k, input logic [23:0] v);
    hw(3*k, v[23:16]); hw(3*k+1, v[15:8]); hw(3*k+2, v[7:0]);
    mstg[3*k] = v[23:16]; mstg[3*k+1] = v[15:8]; mstg[3*k+2] = v[7:0];
  endtask

  task automatic checkStage(input string tag);
    logic [7:0] d;
    for (int i = 0; i < NSTG; i++) begin rdReg(i, d); chk(tag, d, mstg[i]); end
  endtask

  task automatic checkRam(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      filtAddr = 6'(a); #0.2; chk(tag, filtData, mram[a]);
    end
  endtask

  task automatic pulse();
    @(negedge clk); sampleStrobe = 1'b1;
    @(negedge clk); sampleStrobe = 1'b0;
  endtask

  task automatic loadOne(input int a);
    mstg[0] = mram[a][23:16]; mstg[1] = mram[a][15:8]; mstg[2] = mram[a][7:0];
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int bases[4];
    for (int a = 0; a < DEPTH; a++) mram[a] = '0;
    for (int i = 0; i < NSTG; i++) mstg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 busy", busy, 0);
    for (int i = 0; i <= CTRL_OFF; i++) begin rdReg(i, d); chk("R1 reg", d, 0); end
    checkRam("R1 ram");

    // R3 single write sweep over every address
    for (int a = 0; a < DEPTH; a++) begin
      hw(ADDR_OFF, 8'(a));
      putWord(0, coefVal(a, 0));
      hw(CTRL_OFF, 8'h01);
      chk("R3 busy high", busy, 1);
      @(negedge clk);
      chk("R3 busy one cycle", busy, 0);
      mram[a] = coefVal(a, 0);
    end
    checkRam("R3 R11 ram after sweep");
    filtAddr = 6'd62; #0.2; chk("R11 beyond end", filtData, 0);
    filtAddr = 6'd63; #0.2; chk("R11 beyond end", filtData, 0);

    // R2 map
    rdReg(ADDR_OFF, d); chk("R2 addr readback", d, 8'd61);
    rdReg(17, d); chk("R2 unmapped", d, 0);
    rdReg(31, d); chk("R2 unmapped", d, 0);

    // R4 single read
    for (int i = 0; i < NSTG; i++) begin hw(i, 8'h5A); mstg[i] = 8'h5A; end
    bases = '{0, 7, 33, 61};
    foreach (bases[j]) begin
      hw(ADDR_OFF, 8'(bases[j]));
      hw(CTRL_OFF, 8'h04);
      @(negedge clk);
      loadOne(bases[j]);
      checkStage("R4 single read");
    end

    // R5 set read at every biquad base and the last legal base
    for (int b = 0; b <= 50; b += 5) begin
      int base;
      base = (b == 50) ? 57 : b;
      hw(ADDR_OFF, 8'(base));
      hw(CTRL_OFF, 8'h08);
      @(negedge clk);
      for (int k = 0; k < 5; k++) begin
        mstg[3*k] = mram[base+k][23:16];
        mstg[3*k+1] = mram[base+k][15:8];
        mstg[3*k+2] = mram[base+k][7:0];
      end
      checkStage("R5 set read order");
    end

    // R6 atomic set write, R7 locking while busy
    bases = '{0, 20, 45, 57};
    foreach (bases[j]) begin
      for (int k = 0; k < 5; k++) putWord(k, coefVal(bases[j] + k, 7 + j));
      hw(ADDR_OFF, 8'(bases[j]));
      hw(CTRL_OFF, 8'h02);
      sampleStrobe = 1'b1;
      @(negedge clk);
      sampleStrobe = 1'b0;
      chk("R6 strobe in capture cycle ignored", busy, 1);
      hw(0, ~mstg[0]);
      hw(ADDR_OFF, 8'd3);
      rdReg(0, d); chk("R7 staging locked", d, mstg[0]);
      rdReg(ADDR_OFF, d); chk("R7 address locked", d, 8'(bases[j]));
      repeat (4) @(negedge clk);
      checkRam("R6 old set held");
      pulse();
      chk("R6 busy falls at swap", busy, 0);
      for (int k = 0; k < 5; k++) mram[bases[j] + k] = mword(k);
      checkRam("R6 set swapped");
      rdReg(CTRL_OFF, d); chk("R10 command cleared", d, 0);
    end

    // R8 rejection
    for (int k = 0; k < 5; k++) putWord(k, coefVal(k, 77));
    hw(ADDR_OFF, 8'd58);
    hw(CTRL_OFF, 8'h02);
    @(negedge clk);
    chk("R8 set write rejected busy", busy, 0);
    checkRam("R8 set write rejected ram");
    hw(CTRL_OFF, 8'h08);
    @(negedge clk);
    checkStage("R8 set read rejected");
    hw(ADDR_OFF, 8'd62);
    hw(CTRL_OFF, 8'h01);
    @(negedge clk);
    checkRam("R8 single write rejected");
    hw(CTRL_OFF, 8'h04);
    @(negedge clk);
    checkStage("R8 single read rejected");

    // R9 priority
    hw(ADDR_OFF, 8'd10);
    putWord(0, coefVal(99, 1));
    hw(CTRL_OFF, 8'h0F);
    @(negedge clk);
    chk("R9 write-one wins", busy, 0);
    mram[10] = coefVal(99, 1);
    checkRam("R9 write-one wins ram");
    checkStage("R9 no read ran");
    putWord(0, coefVal(98, 2));
    hw(CTRL_OFF, 8'h0C);
    @(negedge clk);
    loadOne(10);
    checkStage("R9 read-one over read-set");
    hw(CTRL_OFF, 8'h0A);
    @(negedge clk);
    chk("R9 write-set over read-set", busy, 1);
    pulse();
    for (int k = 0; k < 5; k++) mram[10 + k] = mword(k);
    checkRam("R9 write-set ram");

    // R10 reserved bits and command readback
    hw(CTRL_OFF, 8'hA0);
    rdReg(CTRL_OFF, d); chk("R10 reserved only", d, 8'hA0);
    chk("R10 no command busy", busy, 0);
    hw(CTRL_OFF, 8'h54);
    rdReg(CTRL_OFF, d); chk("R10 pending read-one", d, 8'h54);
    @(negedge clk);
    loadOne(10);
    rdReg(CTRL_OFF, d); chk("R10 cleared after read", d, 8'h50);
    hw(CTRL_OFF, 8'h02);
    hw(CTRL_OFF, 8'h31);
    rdReg(CTRL_OFF, d); chk("R10 command while busy discarded", d, 8'h32);
    pulse();
    rdReg(CTRL_OFF, d); chk("R10 cleared after swap", d, 8'h30);
    for (int k = 0; k < 5; k++) mram[10 + k] = mword(k);
    checkRam("R10 swap ram");
    checkStage("R10 staging");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule